// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This unit gathers interrupt events from a set of DMA channels (16 by default) and presents them to software through a small register read/write port. Every channel can report four classes of event: the whole descriptor chain finished, one chain node finished, and two independent fault sources. Each class has its own sticky raw latch, its own enable mask and a masked view, which is the raw latch ANDed with the mask. A per-channel summary ORs the four masked views. One level interrupt line stays high while any summary bit is set.

Channel `i` always occupies bit `i` of every register. Software enables events by writing masks. It finds the source by reading the summary and the masked views. It acknowledges an event by writing ones into the raw latch of that class. A write of 1 clears the bit and a write of 0 leaves it alone. When an event arrives in the same cycle as the clear of the same bit, the event is kept. Register offsets are fixed because driver code decodes them.

The register port is run by a two-state machine. In `PS_IDLE` no read data is presented. An accepted read moves it to `PS_RESP`, where `rd_valid` is high for one cycle with the captured data. It returns to `PS_IDLE` unless another read is accepted, in which case it stays in `PS_RESP`. Writes take effect at the clock edge where they are presented and do not change the state.

Top module: `dma_irq_status_unit`

## Requirements
- R1: After reset every raw latch and every mask register is zero, `irq` is low, `rd_valid` is low, and every mapped register reads zero.
- R2: A one-cycle high pulse on bit `i` of an event input sets bit `i` of that class's raw latch from the next clock edge. Event inputs map to classes as follows: chain-done is class 0, node-done is class 1, fault A is class 2 and fault B is class 3. The raw latch of class `k` reads at offset 0x600 + 8*k.
- R3: A write to a raw latch offset clears each bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R4: If an event pulse on bit `i` and a clearing write to bit `i` of the same class happen in the same cycle, the bit is set after that edge.
- R5: The mask of class `k` is at offset 0x18 + 4*k. A write loads write-data bits [NUM_CH-1:0]. A read returns that value, with the upper data bits reading 0. The mask changes only on such a write.
- R6: The masked view of class `k` at offset 0x04 + 4*k reads raw AND mask for that class.
- R7: The summary at offset 0x00 has bit `i` set exactly when bit `i` of any of the four masked views is set.
- R8: `irq` is high exactly while the summary is nonzero. It is a level output that stays high until software clears raw bits or masks them off.
- R9: A read accepted at one edge presents its data on `rd_data` with `rd_valid` high in the following cycle. Unmapped offsets read zero. Writes to the summary, the masked views or unmapped offsets change no state.
- R10: Masking does not block latching: an event on a masked-off channel still sets its raw bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_chain_done | input | NUM_CH | Chain-complete pulses, one bit per channel (class 0) |
| evt_node_done | input | NUM_CH | Node-complete pulses, one bit per channel (class 1) |
| evt_fault_a | input | NUM_CH | Fault source A pulses (class 2) |
| evt_fault_b | input | NUM_CH | Fault source B pulses (class 3) |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | DATA_W | Read data |
| irq | output | 1 | Level interrupt, high while the summary is nonzero |

## Verification
The bench sweeps every channel in every class. It raises one event with the masks closed, then opens that single mask bit, then clears the bit. This sweep exposes swapped class offsets, a mask that blocks latching instead of only hiding the event, and an interrupt that fires while masked. Write-zero-keeps and write-one-clears are checked separately, so a raw register that a write simply loads fails one of them. A same-cycle event and clear on one bit must leave it set; a design that lets the clear win would lose that event. Mixed multi-channel patterns check the summary OR, mask readback with upper data bits set, and that unmapped or read-only offsets neither return stale data nor disturb state.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    localparam int NCLS   = 4;
    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        CLS_CHAIN = 2'd0,
        CLS_NODE  = 2'd1,
        CLS_FLT_A = 2'd2,
        CLS_FLT_B = 2'd3
    } evt_cls_e;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_RESP = 1'b1
    } port_state_e;

    localparam logic [ADDR_W-1:0] OFS_SUMMARY     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_MASKED_BASE = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_MASK_BASE   = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_RAW_BASE    = 12'h600;

    function automatic logic [ADDR_W-1:0] masked_ofs(input int k);
        return OFS_MASKED_BASE + ADDR_W'(4 * k);
    endfunction

    function automatic logic [ADDR_W-1:0] mask_ofs(input int k);
        return OFS_MASK_BASE + ADDR_W'(4 * k);
    endfunction

    function automatic logic [ADDR_W-1:0] raw_ofs(input int k);
        return OFS_RAW_BASE + ADDR_W'(8 * k);
    endfunction

endpackage

// File: rtl/dirq_class_bank.sv
module dirq_class_bank #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_i,
    input  logic              clr_we_i,
    input  logic              mask_we_i,
    input  logic [NUM_CH-1:0] wdata_i,
    output logic [NUM_CH-1:0] raw_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] masked_o
);

    logic [NUM_CH-1:0] raw_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] clr_bits;

    // Clear bits only when the raw offset of this class is written.
    assign clr_bits = clr_we_i ? wdata_i : '0;

    // An event pulse wins over a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | evt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we_i) begin
            mask_q <= wdata_i;
        end
    end

    assign raw_o    = raw_q;
    assign mask_o   = mask_q;
    assign masked_o = raw_q & mask_q;

    assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

    assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((raw_q & $past(wdata_i & ~evt_i)) == '0));

    assert_w0_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((raw_q & $past(raw_q & ~wdata_i)) == $past(raw_q & ~wdata_i)));

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i |=> $stable(mask_q));

    assert_mask_blind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we_i && (evt_i == '0)) |=> $stable(raw_q));

endmodule

// File: rtl/dirq_summary.sv
module dirq_summary
    import dirq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic [NCLS-1:0][NUM_CH-1:0] masked_i,
    output logic [NUM_CH-1:0]           summary_o,
    output logic                        irq_o
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic [NCLS-1:0] per_cls;
        for (genvar k = 0; k < NCLS; k++) begin : g_cls
            assign per_cls[k] = masked_i[k][ch];
        end
        assign summary_o[ch] = |per_cls;
    end

    assign irq_o = |summary_o;

endmodule

// File: rtl/dirq_reg_port.sv
module dirq_reg_port
    import dirq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [NCLS-1:0][NUM_CH-1:0] raw_i,
    input  logic [NCLS-1:0][NUM_CH-1:0] mask_i,
    input  logic [NCLS-1:0][NUM_CH-1:0] masked_i,
    input  logic [NUM_CH-1:0]           summary_i,
    output logic [NCLS-1:0]             clr_we_o,
    output logic [NCLS-1:0]             mask_we_o,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data
);

    port_state_e state_q, state_d;
    logic        wr_acc, rd_acc;
    logic [DATA_W-1:0] rd_mux, rd_data_q;

    assign wr_acc = req_valid && req_write;
    assign rd_acc = req_valid && !req_write;

    // Write strobe decode, one per class and register kind.
    always_comb begin
        for (int k = 0; k < NCLS; k++) begin
            clr_we_o[k]  = wr_acc && (req_addr == raw_ofs(k));
            mask_we_o[k] = wr_acc && (req_addr == mask_ofs(k));
        end
    end

    // Read select; unmapped offsets give zero.
    always_comb begin
        rd_mux = '0;
        if (req_addr == OFS_SUMMARY) begin
            rd_mux = DATA_W'(summary_i);
        end
        for (int k = 0; k < NCLS; k++) begin
            if (req_addr == masked_ofs(k)) rd_mux = DATA_W'(masked_i[k]);
            if (req_addr == mask_ofs(k))   rd_mux = DATA_W'(mask_i[k]);
            if (req_addr == raw_ofs(k))    rd_mux = DATA_W'(raw_i[k]);
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: state_d = rd_acc ? PS_RESP : PS_IDLE;
            PS_RESP: state_d = rd_acc ? PS_RESP : PS_IDLE;
            default: state_d = PS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (rd_acc) begin
            rd_data_q <= rd_mux;
        end else begin
            rd_data_q <= '0;
        end
    end

    // Outputs follow the state.
    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            PS_IDLE: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
            PS_RESP: begin
                rd_valid = 1'b1;
                rd_data  = rd_data_q;
            end
            default: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
        endcase
    end

    assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rd_valid);

    assert_rd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !rd_valid);

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_we_o, mask_we_o}));

endmodule

// File: rtl/dma_irq_status_unit.sv
module dma_irq_status_unit
    import dirq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_chain_done,
    input  logic [NUM_CH-1:0] evt_node_done,
    input  logic [NUM_CH-1:0] evt_fault_a,
    input  logic [NUM_CH-1:0] evt_fault_b,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    logic [NCLS-1:0][NUM_CH-1:0] evt_bus;
    logic [NCLS-1:0][NUM_CH-1:0] raw_bus;
    logic [NCLS-1:0][NUM_CH-1:0] mask_bus;
    logic [NCLS-1:0][NUM_CH-1:0] masked_bus;
    logic [NCLS-1:0]             clr_we;
    logic [NCLS-1:0]             mask_we;
    logic [NUM_CH-1:0]           summary;
    logic [NUM_CH-1:0]           wdata_ch;

    assign evt_bus[CLS_CHAIN] = evt_chain_done;
    assign evt_bus[CLS_NODE]  = evt_node_done;
    assign evt_bus[CLS_FLT_A] = evt_fault_a;
    assign evt_bus[CLS_FLT_B] = evt_fault_b;

    assign wdata_ch = req_wdata[NUM_CH-1:0];

    if (DATA_W > NUM_CH) begin : g_pad
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^req_wdata[DATA_W-1:NUM_CH];
    end

    for (genvar k = 0; k < NCLS; k++) begin : g_bank
        dirq_class_bank #(.NUM_CH(NUM_CH)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_bus[k]),
            .clr_we_i  (clr_we[k]),
            .mask_we_i (mask_we[k]),
            .wdata_i   (wdata_ch),
            .raw_o     (raw_bus[k]),
            .mask_o    (mask_bus[k]),
            .masked_o  (masked_bus[k])
        );
    end

    dirq_summary #(.NUM_CH(NUM_CH)) u_summary (
        .masked_i  (masked_bus),
        .summary_o (summary),
        .irq_o     (irq)
    );

    dirq_reg_port #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .raw_i     (raw_bus),
        .mask_i    (mask_bus),
        .masked_i  (masked_bus),
        .summary_i (summary),
        .clr_we_o  (clr_we),
        .mask_we_o (mask_we),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // Level interrupt holds while software neither clears nor re-masks.
    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && (clr_we == '0) && (mask_we == '0)) |=> irq);

    // Interrupt cannot rise without a new event or a mask change.
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && (evt_bus == '0) && (mask_we == '0)) |=> !irq);

endmodule

// File: tb/dma_irq_status_unit_tb.sv
module dma_irq_status_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int DW  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0][NCH-1:0] evt = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rd_valid, irq;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [NCH-1:0] exp_raw  [4];
    logic [NCH-1:0] exp_mask [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_status_unit #(.NUM_CH(NCH), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_chain_done(evt[0]), .evt_node_done(evt[1]),
        .evt_fault_a(evt[2]), .evt_fault_b(evt[3]),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [11:0] a_raw(int k);    return 12'h600 + 12'(8*k); endfunction
    function automatic logic [11:0] a_mask(int k);   return 12'h018 + 12'(4*k); endfunction
    function automatic logic [11:0] a_masked(int k); return 12'h004 + 12'(4*k); endfunction

    function automatic logic [NCH-1:0] exp_summary();
        logic [NCH-1:0] s = '0;
        for (int k = 0; k < 4; k++) s |= exp_raw[k] & exp_mask[k];
        return s;
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [11:0] a, logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (a == a_raw(k))  exp_raw[k]  &= ~d[NCH-1:0];
            if (a == a_mask(k)) exp_mask[k] = d[NCH-1:0];
        end
    endtask

    task automatic reg_read(string tag, logic [11:0] a, logic [DW-1:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " rd_valid"}, DW'(rd_valid), DW'(1));
        check(tag, rd_data, exp);
    endtask

    task automatic pulse(int k, logic [NCH-1:0] bits);
        @(negedge clk);
        evt[k] = bits;
        @(negedge clk);
        evt[k] = '0;
        exp_raw[k] |= bits;
    endtask

    task automatic read_all(string tag);
        reg_read({tag, " R7 summary"}, 12'h000, DW'(exp_summary()));
        for (int k = 0; k < 4; k++) begin
            reg_read({tag, " R2 raw"}, a_raw(k), DW'(exp_raw[k]));
            reg_read({tag, " R5 mask"}, a_mask(k), DW'(exp_mask[k]));
            reg_read({tag, " R6 masked"}, a_masked(k), DW'(exp_raw[k] & exp_mask[k]));
        end
        check({tag, " R8 irq"}, DW'(irq), DW'(exp_summary() != '0));
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin exp_raw[k] = '0; exp_mask[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", DW'(irq), '0);
        check("R1 rd_valid", DW'(rd_valid), '0);
        read_all("R1 reset");

        // R9: unmapped reads and writes to read-only offsets
        reg_read("R9 unmapped 0x014", 12'h014, '0);
        reg_read("R9 unmapped 0x604", 12'h604, '0);
        reg_read("R9 unmapped 0x7fc", 12'h7fc, '0);
        pulse(0, 16'h0001);
        reg_write(12'h000, 32'hffff_ffff);
        reg_write(12'h004, 32'hffff_ffff);
        reg_write(12'h604, 32'hffff_ffff);
        reg_write(12'h028, 32'hffff_ffff);
        read_all("R9 ro-write");
        reg_write(a_raw(0), 32'h0000_0001);

        // Sweep every class and channel
        for (int k = 0; k < 4; k++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                logic [NCH-1:0] b;
                b = NCH'(1) << ch;
                pulse(k, b);
                reg_read("R2 raw set", a_raw(k), DW'(b));
                reg_read("R10 masked-off view", a_masked(k), '0);
                check("R10 irq masked", DW'(irq), '0);
                reg_write(a_mask(k), DW'(b));
                reg_read("R6 masked view", a_masked(k), DW'(b));
                reg_read("R7 summary", 12'h000, DW'(b));
                check("R8 irq high", DW'(irq), DW'(1));
                reg_write(a_raw(k), DW'(~b));
                reg_read("R3 write0 keeps", a_raw(k), DW'(b));
                reg_write(a_raw(k), DW'(b));
                reg_read("R3 write1 clears", a_raw(k), '0);
                check("R8 irq low", DW'(irq), '0);
                reg_write(a_mask(k), '0);
            end
        end

        // R5: mask readback ignores upper data bits
        for (int k = 0; k < 4; k++) begin
            reg_write(a_mask(k), 32'hdead_0000 | DW'(16'h1234 + 16'(k * 16'h1111)));
            reg_read("R5 mask readback", a_mask(k), DW'(exp_mask[k]));
        end

        // R6/R7: mixed multi-channel patterns
        pulse(0, 16'h8421);
        pulse(1, 16'h0f0f);
        pulse(2, 16'hc003);
        pulse(3, 16'h1248);
        read_all("R7 mixed");
        reg_write(a_mask(1), 32'h0000_00f0);
        reg_write(a_mask(3), 32'h0000_ffff);
        read_all("R7 remask");

        // R4: event and clear on the same bit in the same cycle
        for (int k = 0; k < 4; k++) reg_write(a_raw(k), 32'h0000_ffff);
        pulse(2, 16'h0010);
        @(negedge clk);
        evt[2] = 16'h0010;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a_raw(2); req_wdata = 32'h0000_0030;
        @(negedge clk);
        evt[2] = '0; req_valid = 1'b0; req_write = 1'b0;
        exp_raw[2] = 16'h0010;
        reg_read("R4 event wins", a_raw(2), DW'(16'h0010));

        // R8: level held across idle cycles
        reg_write(a_mask(2), 32'h0000_0010);
        repeat (20) @(negedge clk);
        check("R8 level held", DW'(irq), DW'(1));
        reg_write(a_mask(2), '0);
        check("R8 mask drops irq", DW'(irq), DW'(exp_summary() != '0));
        read_all("R8 final");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule